// File: doc/BRIEF.md
# Modem Control and Status Unit

This unit sits beside a serial port and handles the modem handshake lines. A four-bit control register drives the two active-low request outputs (request-to-send and data-terminal-ready) and stores two auxiliary bits. A status byte has two halves. The upper half shows the asserted level of the four active-low inputs: clear-to-send, data-set-ready, carrier-detect and ring-indicator. The lower half holds sticky change flags, one per input.

The external inputs pass through a two-stage synchronizer. Each change is then latched as a change flag. The flags stay set until the CPU reads the status byte. While any flag is set and the interrupt enable input is high, the unit raises an interrupt request. A loopback input selects a diagnostic mode. In that mode the external input pins are ignored and the control bits take the place of the four inputs. Both request outputs are then held at their inactive high level.

Top module: `modem_ctl_stat`

## Requirements
- R1: A write pulse `ctrl_we` loads `ctrl_wdata` into the control register: bit 0 is DTR, bit 1 is RTS, bit 2 is AUX1 and bit 3 is AUX2. The value appears on `ctrl_rdata` from the next cycle. The reset value is 0.
- R2: Outside loopback, `rts_n` is the complement of control bit 1 and `dtr_n` is the complement of control bit 0. After reset both outputs are 1.
- R3: Outside loopback, `stat_rdata[7:4]` shows the complement of `dcd_n`, `ri_n`, `dsr_n` and `cts_n` for bits 7, 6, 5 and 4, two clock edges after a pin changes.
- R4: In loopback, status bit 7 shows AUX2, bit 6 shows AUX1, bit 5 shows DTR and bit 4 shows RTS. `rts_n` and `dtr_n` are held at 1.
- R5: The change flags for CTS (bit 0), DSR (bit 1) and CD (bit 3) are set whenever the matching status level changes in either direction.
- R6: The RI change flag (bit 2) is set only when the ring-indicator level falls, which is `ri_n` going from 0 to 1. A rising level leaves the flag clear.
- R7: A status read (`stat_rd` high for a cycle) returns the flags in that cycle and clears all four flags at the end of the cycle.
- R8: When a change event and a status read fall on the same clock edge, the flag for the new event stays set after the read.
- R9: `irq` is 1 exactly when `irq_en` is 1 and at least one change flag is set.
- R10: In loopback, changes on the four external input pins affect neither the status byte nor the change flags.
- R11: After reset, with the input pins idle high, `stat_rdata` is 0x00 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control write data {AUX2, AUX1, RTS, DTR} |
| ctrl_rdata | output | 4 | Control register contents |
| stat_rd | input | 1 | Status read strobe, clears change flags |
| stat_rdata | output | 8 | Status byte {CD, RI, DSR, CTS, dCD, tRI, dDSR, dCTS} |
| loopback | input | 1 | Diagnostic loopback enable |
| irq_en | input | 1 | Modem interrupt enable |
| irq | output | 1 | Modem status interrupt request |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| dcd_n | input | 1 | Carrier-detect, active low |
| ri_n | input | 1 | Ring indicator, active low |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |

## Verification
The assertions assume that `ctrl_we` and `stat_rd` are single-cycle strobes sampled on the rising edge. They also assume that `loopback` changes only while the flags it would disturb are later cleared by a read. The stimulus drives every input on the falling edge. After each pin change it waits several cycles before sampling, so the synchronizer delay has always elapsed. Each mode switch is followed by a clearing read before any flag value is checked. The one same-edge read-and-change case is set up on purpose with a control write, so that its timing is exact.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int NLINES  = 4;
    localparam int CTRL_W  = 4;
    localparam int STAT_W  = 2 * NLINES;
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_CD  = 3;

    // control register layout, bit 3 down to bit 0
    typedef struct packed {
        logic aux2;
        logic aux1;
        logic rts;
        logic dtr;
    } mdm_ctrl_t;

    // asserted line levels, same order as status bits 7..4 and flags 3..0
    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    typedef enum logic {
        SRC_PINS = 1'b0,
        SRC_LOOP = 1'b1
    } mdm_src_e;

    // loopback wiring of control bits onto the status levels
    function automatic mdm_lines_t loop_map(input mdm_ctrl_t c);
        mdm_lines_t l;
        l.cd  = c.aux2;
        l.ri  = c.aux1;
        l.dsr = c.dtr;
        l.cts = c.rts;
        return l;
    endfunction

    // active-low synchronized pins {dcd_n, ri_n, dsr_n, cts_n} to asserted levels
    function automatic mdm_lines_t pins_to_lines(input logic [NLINES-1:0] pins_n);
        return mdm_lines_t'(~pins_n);
    endfunction

    // change events: any edge, except ring indicator which reports its trailing edge only
    function automatic logic [NLINES-1:0] change_events(input mdm_lines_t prev,
                                                        input mdm_lines_t cur);
        logic [NLINES-1:0] ev;
        ev         = prev ^ cur;
        ev[IDX_RI] = prev.ri & ~cur.ri;
        return ev;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int          WIDTH     = 4,
    parameter int          STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= {WIDTH{RESET_VAL}};
                    else     stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= {WIDTH{RESET_VAL}};
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[LAST];

endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
    import mdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  mdm_ctrl_t wdata,
    output mdm_ctrl_t q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata;
    end

    // R1: a write is visible on the next cycle
    assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(wdata)));

endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mdm_lines_t        lvl,
    input  logic              clr,
    output logic [NLINES-1:0] flags
);
    mdm_lines_t        prev_q;
    logic [NLINES-1:0] events;
    logic [NLINES-1:0] flags_d;

    always_comb begin
        events  = change_events(prev_q, lvl);
        // a new event on the clearing edge survives the clear
        flags_d = (flags & ~{NLINES{clr}}) | events;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            flags  <= '0;
        end else begin
            prev_q <= lvl;
            flags  <= flags_d;
        end
    end

    // R6: a falling ring level always leaves the ring flag set
    assert_ri_trailing_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(lvl.ri) |=> flags[IDX_RI]);

    // R6: a rising ring level never raises the ring flag by itself
    assert_ri_no_lead_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(lvl.ri) && !flags[IDX_RI]) |=> !flags[IDX_RI]);

    // R7: a read with no change pending empties all flags
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && $stable(lvl)) |=> (flags == '0));

    // R8: a CTS change on a read edge keeps its flag
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && $changed(lvl.cts)) |=> flags[IDX_CTS]);

endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_we,
    input  logic [3:0]  ctrl_wdata,
    output logic [3:0]  ctrl_rdata,
    input  logic        stat_rd,
    output logic [7:0]  stat_rdata,
    input  logic        loopback,
    input  logic        irq_en,
    output logic        irq,
    input  logic        cts_n,
    input  logic        dsr_n,
    input  logic        dcd_n,
    input  logic        ri_n,
    output logic        rts_n,
    output logic        dtr_n
);
    mdm_ctrl_t         ctrl_q;
    logic [NLINES-1:0] pins_sync_n;
    mdm_lines_t        lvl_pins;
    mdm_lines_t        lvl_sel;
    logic [NLINES-1:0] flags;
    mdm_src_e          src;

    mdm_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl_we),
        .wdata (mdm_ctrl_t'(ctrl_wdata)),
        .q     (ctrl_q)
    );

    mdm_sync #(
        .WIDTH     (NLINES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dcd_n, ri_n, dsr_n, cts_n}),
        .q   (pins_sync_n)
    );

    always_comb begin
        src      = loopback ? SRC_LOOP : SRC_PINS;
        lvl_pins = pins_to_lines(pins_sync_n);
        case (src)
            SRC_LOOP: lvl_sel = loop_map(ctrl_q);
            default:  lvl_sel = lvl_pins;
        endcase
    end

    mdm_delta u_delta (
        .clk   (clk),
        .rst   (rst),
        .lvl   (lvl_sel),
        .clr   (stat_rd),
        .flags (flags)
    );

    always_comb begin
        ctrl_rdata = ctrl_q;
        stat_rdata = {lvl_sel, flags};
        irq        = irq_en & (|flags);
        rts_n      = (src == SRC_LOOP) ? 1'b1 : ~ctrl_q.rts;
        dtr_n      = (src == SRC_LOOP) ? 1'b1 : ~ctrl_q.dtr;
    end

    // R9: a request is never raised while disabled
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en);

    // R9: a read with steady levels drops the request on the next cycle
    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && $stable(stat_rdata[7:4])) |=> !irq);

    // R2: outside loopback, a control write reaches the pins on the next cycle
    assert_pin_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !loopback) ##1 !loopback |-> (rts_n == !$past(ctrl_wdata[1])));

endmodule

// File: tb/modem_ctl_stat_tb.sv
module modem_ctl_stat_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctrl_we;
    logic [3:0] ctrl_wdata;
    logic [3:0] ctrl_rdata;
    logic       stat_rd;
    logic [7:0] stat_rdata;
    logic       loopback;
    logic       irq_en;
    logic       irq;
    logic       cts_n, dsr_n, dcd_n, ri_n;
    logic       rts_n, dtr_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    modem_ctl_stat u_dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .loopback(loopback), .irq_en(irq_en), .irq(irq),
        .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n), .ri_n(ri_n),
        .rts_n(rts_n), .dtr_n(dtr_n)
    );

    // pins {dcd_n, ri_n, dsr_n, cts_n}, expected status byte after settling
    localparam int NV = 9;
    localparam logic [11:0] VEC [NV] = '{
        {4'b1110, 8'h11},  // R5 cts asserted
        {4'b1100, 8'h32},  // R5 dsr asserted
        {4'b1000, 8'h70},  // R6 ring leading edge, no flag
        {4'b1100, 8'h34},  // R6 ring trailing edge
        {4'b0100, 8'hB8},  // R5 carrier asserted
        {4'b0101, 8'hA1},  // R5 cts released
        {4'b1111, 8'h0A},  // R5 carrier and dsr released
        {4'b0000, 8'hFB},  // R6 all asserted, ring flag stays clear
        {4'b1111, 8'h0F}   // R6 all released, all flags
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic rd_clear();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        rst = 1'b1; ctrl_we = 1'b0; ctrl_wdata = '0; stat_rd = 1'b0;
        loopback = 1'b0; irq_en = 1'b0;
        {dcd_n, ri_n, dsr_n, cts_n} = 4'hF;
        ticks(3);
        rst = 1'b0;
        ticks(4);

        // R11 reset state
        check("R11 status", stat_rdata, 8'h00);
        check("R11 irq", {7'd0, irq}, 8'h00);
        check("R1 ctrl reset", {4'd0, ctrl_rdata}, 8'h00);
        check("R2 pins reset", {6'd0, rts_n, dtr_n}, 8'h03);

        // R1 R2 control writes
        wr_ctrl(4'b0011);
        check("R1 ctrl", {4'd0, ctrl_rdata}, 8'h03);
        check("R2 pins both", {6'd0, rts_n, dtr_n}, 8'h00);
        wr_ctrl(4'b1110);
        check("R1 ctrl aux", {4'd0, ctrl_rdata}, 8'h0E);
        check("R2 rts only", {6'd0, rts_n, dtr_n}, 8'h01);

        // R3 R5 R6 R7 pin pattern table
        for (int v = 0; v < NV; v++) begin
            {dcd_n, ri_n, dsr_n, cts_n} = VEC[v][11:8];
            ticks(5);
            check($sformatf("R3 R5 R6 vec%0d", v), stat_rdata, VEC[v][7:0]);
            rd_clear();
            check($sformatf("R7 cleared vec%0d", v), {4'd0, stat_rdata[3:0]}, 8'h00);
        end

        // R9 interrupt gating
        cts_n = 1'b0;
        ticks(5);
        check("R9 disabled", {7'd0, irq}, 8'h00);
        irq_en = 1'b1;
        #1;
        check("R9 enabled", {7'd0, irq}, 8'h01);
        rd_clear();
        check("R9 after read", {7'd0, irq}, 8'h00);
        cts_n = 1'b1;
        ticks(5);
        rd_clear();

        // R4 loopback mapping
        wr_ctrl(4'b0000);
        loopback = 1'b1;
        ticks(2);
        rd_clear();
        check("R4 pins held", {6'd0, rts_n, dtr_n}, 8'h03);
        wr_ctrl(4'b1010);
        ticks(2);
        check("R4 map cd cts", stat_rdata, 8'h99);
        check("R4 pins held active", {6'd0, rts_n, dtr_n}, 8'h03);
        rd_clear();
        wr_ctrl(4'b0110);
        ticks(2);
        check("R4 R5 map ri rise", stat_rdata, 8'h58);
        rd_clear();
        wr_ctrl(4'b0010);
        ticks(2);
        check("R6 loop ri fall", stat_rdata, 8'h14);
        rd_clear();

        // R10 external pins ignored
        {dcd_n, ri_n, dsr_n, cts_n} = 4'h0;
        ticks(6);
        check("R10 pins ignored", stat_rdata, 8'h10);

        // R8 change and read on the same edge
        wr_ctrl(4'b0011);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R8 set wins", stat_rdata, 8'h32);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule